// File: doc/BRIEF.md
# Mixed-Access Control Register Bank

A small bank of byte-wide registers sits on a simple synchronous parallel bus with an address, write data, read data, a write strobe and a read strobe. Each field has its own access behaviour. Plain read/write control bits drive configuration outputs. Write-only bits drive outputs but always read as zero. Write-to-pulse command bits produce a one-cycle strobe and read as zero. Sticky status bits are set by hardware pulses and cleared by software writing a clear value that is chosen per register. A read-only window returns live hardware status and ignores writes.

The block also makes its own internal reset from an asynchronous active-low input. The input is synchronised and must stay low for `DEB_CYCLES` consecutive clocks before the internal reset asserts. A short glitch is therefore filtered out. Release is synchronised through the same two flops.

Address map (default widths): 0 = control (bits 3:0 read/write, bits 7:4 write-only), 1 = command pulses, 2 = status A (a bit clears when written with 1), 3 = status B (a bit clears when written with 0), 4 = read-only hardware window. Addresses 5 and above are unmapped.

Top module: `ctl_regbank`

## Requirements
- R1: After the debounced reset, ctrl_o, wo_o, strobe_o, rdata_o and both status registers are all zero.
- R2: A write to address 0 stores wdata[3:0]. The stored value drives ctrl_o from the cycle after the write and reads back in read bits 3:0.
- R3: A write to address 0 stores wdata[7:4], which then drives wo_o. A read of address 0 always returns zero in bits 7:4.
- R4: A write to address 1 raises each strobe_o bit that is 1 in wdata for exactly one cycle, the cycle after the write. A read of address 1 returns zero.
- R5: A status A bit (address 2) is set by a one-cycle pulse on hw_seta_i. Writing 1 to the bit clears it. Writing 0 to the bit leaves it unchanged.
- R6: A status B bit (address 3) is set by a pulse on hw_setb_i. Writing 0 to the bit clears it. Writing 1 to the bit leaves it unchanged.
- R7: When a hardware set pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R8: A read of address 4 returns hw_stat_i. A write to address 4 changes no register and no output.
- R9: rdata_o is registered. It is valid in the cycle after the read strobe and holds its value while no read is made. Unmapped addresses read as zero.
- R10: If rst_ni is low for fewer than DEB_CYCLES clocks, nothing is reset. If it is held low for DEB_CYCLES or more clocks, every register returns to its reset value, and the bank is writable again after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low master reset, debounced internally |
| addr_i | input | AW (4) | Register address |
| wdata_i | input | DW (8) | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DW (8) | Registered read data |
| ctrl_o | output | CW (4) | Read/write control bits |
| wo_o | output | DW-CW (4) | Write-only control bits |
| strobe_o | output | DW (8) | One-cycle command strobes |
| hw_seta_i | input | DW (8) | Set pulses for status A |
| hw_setb_i | input | DW (8) | Set pulses for status B |
| hw_stat_i | input | DW (8) | Live hardware status for the read-only window |

## Verification
The bench goes after the same-cycle collision of a hardware set and a software clear. A design that let the clear win would drop an event and read back zero. It checks both clear polarities, with a write of the non-clearing value that must leave the bits untouched; a polarity mix-up would clear the wrong bits or clear nothing. Reads of write-only and pulse bits must return zero, so a design that leaked stored data would show nonzero read data. A short low glitch on the reset input must leave the programmed control value in place, while a long one must clear it; an undebounced reset would lose the value on the glitch.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  localparam int ADR_CTRL = 0;
  localparam int ADR_CMD  = 1;
  localparam int ADR_STA  = 2;
  localparam int ADR_STB  = 3;
  localparam int ADR_HWIN = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CMD,
    SEL_STA,
    SEL_STB,
    SEL_HWIN
  } reg_sel_e;
endpackage

// File: rtl/ctl_rst_debounce.sv
module ctl_rst_debounce #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  localparam int CNTW = $clog2(DEB_CYCLES + 1);

  logic            sync1_q, sync2_q;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            act_q, act_d;

  // The synchroniser cannot be reset by the signal it filters.
  always_ff @(posedge clk_i) begin
    sync1_q <= arst_ni;
    sync2_q <= sync1_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (sync2_q) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else begin
      if (cnt_q != CNTW'(DEB_CYCLES)) cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNTW'(DEB_CYCLES - 1)) act_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    cnt_q <= cnt_d;
    act_q <= act_d;
  end

  assign rst_no = ~act_q;
endmodule

// File: rtl/ctl_pulse_bank.sv
module ctl_pulse_bank #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] strobe_o
);
  logic [DW-1:0] strobe_q, strobe_d;

  always_comb begin
    strobe_d = '0;
    if (fire_i) strobe_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= '0;
    else         strobe_q <= strobe_d;
  end

  assign strobe_o = strobe_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> (strobe_o == '0)); // R4
endmodule

// File: rtl/ctl_clr_status.sv
module ctl_clr_status #(
  parameter int            DW      = 8,
  parameter logic [DW-1:0] CLR_VAL = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] stat_o
);
  logic [DW-1:0] stat_q, stat_d;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic clr_hit;
    assign clr_hit   = clr_wr_i && (wdata_i[i] == CLR_VAL[i]);
    assign stat_d[i] = set_i[i] | (stat_q[i] & ~clr_hit);

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> stat_o[i]); // R7
    AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_wr_i && wdata_i[i] == CLR_VAL[i] && !set_i[i]) |=> !stat_o[i]); // R5
    AST_NOCLR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_wr_i && wdata_i[i] != CLR_VAL[i]) |=> $stable(stat_o[i]) || stat_o[i]); // R6
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int            AW         = 4,
  parameter int            DW         = 8,
  parameter int            CW         = 4,
  parameter int            DEB_CYCLES = 16,
  parameter logic [DW-1:0] STA_CLR    = '1,
  parameter logic [DW-1:0] STB_CLR    = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [DW-1:0]    rdata_o,
  output logic [CW-1:0]    ctrl_o,
  output logic [DW-CW-1:0] wo_o,
  output logic [DW-1:0]    strobe_o,
  input  logic [DW-1:0]    hw_seta_i,
  input  logic [DW-1:0]    hw_setb_i,
  input  logic [DW-1:0]    hw_stat_i
);
  localparam int WW = DW - CW;

  logic          rst_n;
  reg_sel_e      sel;
  logic          wr_ctrl, wr_cmd, wr_sta, wr_stb;
  logic [CW-1:0] ctrl_q, ctrl_d;
  logic [WW-1:0] wo_q, wo_d;
  logic [DW-1:0] sta, stb;
  logic [DW-1:0] rdata_q, rdata_d, rmux;

  ctl_rst_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n)
  );

  always_comb begin
    if      (addr_i == AW'(ADR_CTRL)) sel = SEL_CTRL;
    else if (addr_i == AW'(ADR_CMD))  sel = SEL_CMD;
    else if (addr_i == AW'(ADR_STA))  sel = SEL_STA;
    else if (addr_i == AW'(ADR_STB))  sel = SEL_STB;
    else if (addr_i == AW'(ADR_HWIN)) sel = SEL_HWIN;
    else                              sel = SEL_NONE;
  end

  assign wr_ctrl = wr_i && (sel == SEL_CTRL);
  assign wr_cmd  = wr_i && (sel == SEL_CMD);
  assign wr_sta  = wr_i && (sel == SEL_STA);
  assign wr_stb  = wr_i && (sel == SEL_STB);

  // control register: read/write low field, write-only high field
  always_comb begin
    ctrl_d = ctrl_q;
    wo_d   = wo_q;
    if (wr_ctrl) begin
      ctrl_d = wdata_i[CW-1:0];
      wo_d   = wdata_i[DW-1:CW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      wo_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      wo_q   <= wo_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign wo_o   = wo_q;

  ctl_pulse_bank #(.DW(DW)) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .fire_i   (wr_cmd),
    .wdata_i  (wdata_i),
    .strobe_o (strobe_o)
  );

  ctl_clr_status #(.DW(DW), .CLR_VAL(STA_CLR)) u_sta (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .clr_wr_i (wr_sta),
    .wdata_i  (wdata_i),
    .set_i    (hw_seta_i),
    .stat_o   (sta)
  );

  ctl_clr_status #(.DW(DW), .CLR_VAL(STB_CLR)) u_stb (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .clr_wr_i (wr_stb),
    .wdata_i  (wdata_i),
    .set_i    (hw_setb_i),
    .stat_o   (stb)
  );

  // read path
  always_comb begin
    unique case (sel)
      SEL_CTRL: rmux = {{WW{1'b0}}, ctrl_q};
      SEL_STA:  rmux = sta;
      SEL_STB:  rmux = stb;
      SEL_HWIN: rmux = hw_stat_i;
      default:  rmux = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_i) rdata_d = rmux;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  AST_RW_STORE: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_o == $past(wdata_i[CW-1:0]))); // R2
  AST_WO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_i && sel == SEL_CTRL) |=> (rdata_o[DW-1:CW] == '0)); // R3
  AST_CMD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_i && sel == SEL_CMD) |=> (rdata_o == '0)); // R4
  AST_RO_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_i && sel == SEL_HWIN) |=> ($stable(ctrl_o) && $stable(wo_o))); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_i && sel == SEL_NONE) |=> (rdata_o == '0)); // R9
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o)); // R9
endmodule

// File: tb/ctl_regbank_test.sv
module ctl_regbank_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       wr, rd;
  logic [7:0] rdata;
  logic [3:0] ctrl;
  logic [3:0] wo;
  logic [7:0] strobe;
  logic [7:0] seta, setb, hwst;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ctl_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .ctrl_o(ctrl), .wo_o(wo),
    .strobe_o(strobe), .hw_seta_i(seta), .hw_setb_i(setb), .hw_stat_i(hwst)
  );

  // op(1) addr(4) data(8) expect(8); op 0 = write, 1 = read and compare
  localparam logic [20:0] VEC [12] = '{
    {1'b0, 4'd0,  8'h5A, 8'h00},
    {1'b1, 4'd0,  8'h00, 8'h0A},
    {1'b1, 4'd1,  8'h00, 8'h00},
    {1'b0, 4'd4,  8'hFF, 8'h00},
    {1'b1, 4'd4,  8'h00, 8'hA5},
    {1'b1, 4'd0,  8'h00, 8'h0A},
    {1'b1, 4'd7,  8'h00, 8'h00},
    {1'b1, 4'd15, 8'h00, 8'h00},
    {1'b0, 4'd0,  8'hF3, 8'h00},
    {1'b1, 4'd0,  8'h00, 8'h03},
    {1'b1, 4'd2,  8'h00, 8'h00},
    {1'b1, 4'd3,  8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b1; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0;
    seta = '0; setb = '0; hwst = 8'hA5;
    wait_cyc(3);
    rst_n = 1'b0;
    wait_cyc(20);
    rst_n = 1'b1;
    wait_cyc(6);

    // R1 reset state
    check("R1 ctrl", {4'h0, ctrl}, 8'h00);
    check("R1 wo", {4'h0, wo}, 8'h00);
    check("R1 strobe", strobe, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    do_read(4'd2, v); check("R1 sta", v, 8'h00);
    do_read(4'd3, v); check("R1 stb", v, 8'h00);

    // table walk (R2/R3/R4/R8/R9)
    for (int k = 0; k < 12; k++) begin
      if (VEC[k][20] == 1'b0) do_write(VEC[k][19:16], VEC[k][15:8]);
      else begin
        do_read(VEC[k][19:16], v);
        check($sformatf("R2/R3/R8/R9 vector %0d", k), v, VEC[k][7:0]);
      end
    end

    // R2 and R3 outputs
    do_write(4'd0, 8'hC9);
    check("R2 ctrl_o", {4'h0, ctrl}, 8'h09);
    check("R3 wo_o", {4'h0, wo}, 8'h0C);
    do_read(4'd0, v); check("R3 read zero high", v, 8'h09);

    // R4 pulse
    do_write(4'd1, 8'h81);
    check("R4 strobe high", strobe, 8'h81);
    @(negedge clk);
    check("R4 strobe low", strobe, 8'h00);
    do_read(4'd1, v); check("R4 read zero", v, 8'h00);

    // R5 status A clears on 1
    seta = 8'h0C; @(negedge clk); seta = '0;
    do_read(4'd2, v); check("R5 set", v, 8'h0C);
    do_write(4'd2, 8'h04);
    do_read(4'd2, v); check("R5 clear by 1", v, 8'h08);
    do_write(4'd2, 8'h00);
    do_read(4'd2, v); check("R5 zero no effect", v, 8'h08);

    // R6 status B clears on 0
    setb = 8'h30; @(negedge clk); setb = '0;
    do_write(4'd3, 8'hFF);
    do_read(4'd3, v); check("R6 one no effect", v, 8'h30);
    do_write(4'd3, 8'hEF);
    do_read(4'd3, v); check("R6 clear by 0", v, 8'h20);

    // R7 collision: set wins
    addr = 4'd2; wdata = 8'hFF; wr = 1'b1; seta = 8'h09;
    @(negedge clk);
    wr = 1'b0; seta = '0;
    do_read(4'd2, v); check("R7 sta collision", v, 8'h09);
    addr = 4'd3; wdata = 8'h00; wr = 1'b1; setb = 8'h20;
    @(negedge clk);
    wr = 1'b0; setb = '0;
    do_read(4'd3, v); check("R7 stb collision", v, 8'h20);

    // R9 read data holds without a read strobe
    do_read(4'd2, v);
    seta = 8'h40; @(negedge clk); seta = '0;
    @(negedge clk);
    check("R9 hold", rdata, 8'h09);
    do_read(4'd2, v); check("R9 new read", v, 8'h49);

    // R10 debounce
    do_write(4'd0, 8'h05);
    rst_n = 1'b0; wait_cyc(5); rst_n = 1'b1;
    wait_cyc(4);
    do_read(4'd0, v); check("R10 glitch ignored", v, 8'h05);
    rst_n = 1'b0; wait_cyc(25); rst_n = 1'b1;
    wait_cyc(6);
    check("R10 long reset ctrl", {4'h0, ctrl}, 8'h00);
    do_read(4'd2, v); check("R10 long reset sta", v, 8'h00);
    do_write(4'd0, 8'h06);
    do_read(4'd0, v); check("R10 writable after", v, 8'h06);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule